// File: doc/BRIEF.md
# Character LCD Busy-Polling Controller

This block sits on the host side of a parallel character LCD module and drives its 8-bit bus. The module holds two byte-wide registers. With the register-select line low, a write goes to the command register: clear, cursor moves, display control and RAM address settings. With it high, the byte is a character code for the display RAM, which has 80 entries. The host hands the controller one request at a time on a valid/ready handshake. A request carries a kind code and a byte. The controller turns it into a full bus cycle: register select, read/write line, enable strobe and data bus.

Before every write the controller reads the module's status and checks the busy flag, which is bit 7 of a status read taken with register select low. It writes only once that flag reads 0. It therefore needs no table of worst-case command delays. The data bus is driven only during write cycles and is released during status reads.

After reset the controller waits a programmable power-up delay and then sends a fixed start-up sequence. If the module stays busy for too many status reads in a row, the controller gives up on the pending byte, raises an error flag and returns to idle. Character codes 0 to 7 show the user-defined glyphs. They are sent as ordinary characters.

Top module: `lcd_char_ctrl`

## Requirements
- R1: During reset and for PWRUP_CYCLES cycles after reset is released, lcd_en and lcd_db_oe stay 0, and req_ready, err_timeout and init_done are 0.
- R2: After the power-up delay the controller writes 0x38, 0x0C, 0x01 and 0x06 in that order, all with lcd_rs=0. It then sets init_done=1 and enters idle.
- R3: Every write is preceded by a status read with lcd_rs=0 and lcd_rw=1 that returned lcd_db_in[7]=0. While bit 7 reads 1, the controller keeps issuing status reads and issues no write.
- R4: lcd_db_oe is 1 only while lcd_rw=0 during a write access. It is 0 during status reads and in idle.
- R5: lcd_rs and lcd_rw are stable for at least SETUP_CYCLES (default 2) cycles before lcd_en rises. lcd_rs, lcd_rw and lcd_db_out do not change while lcd_en is high.
- R6: lcd_en stays high for exactly EN_CYCLES cycles (default 12). lcd_rs and lcd_rw then hold their values for HOLD_CYCLES cycles (default 2) after it falls.
- R7: The request kind selects the write. Kind 2'b00 writes req_data with lcd_rs=0. Kind 2'b01 writes req_data with lcd_rs=1. Kind 2'b10 or 2'b11 writes 0x80 | req_data[6:0] with lcd_rs=0; the second display line begins at address 0x40.
- R8: req_ready is 1 only in idle, and a request is taken when req_valid and req_ready are both 1. The stored byte is the one that is written, whatever the request inputs do afterwards. With p busy reads, req_ready returns after (2+p)·(1+SETUP_CYCLES+EN_CYCLES+HOLD_CYCLES) cycles.
- R9: If POLL_LIMIT status reads in a row show busy, the controller raises err_timeout, drops the request without writing it, and returns to idle. POLL_LIMIT−1 busy reads still lead to the write. err_timeout clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 command, 01 character, 1x cursor address |
| req_data | input | 8 | Request byte |
| req_ready | output | 1 | Controller idle and able to take a request |
| err_timeout | output | 1 | Busy flag stuck past the poll limit |
| init_done | output | 1 | Start-up sequence completed |
| lcd_rs | output | 1 | Register select (0 command/status, 1 data) |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_en | output | 1 | Enable strobe |
| lcd_db_out | output | 8 | Data bus value to drive |
| lcd_db_oe | output | 1 | Data bus output enable |
| lcd_db_in | input | 8 | Data bus value read from the module |

## Verification
The assertions check the cycle-level bus rules on every clock. They check that the bus is driven only during writes, that the select lines are set up before and held through the strobe, that the strobe has its fixed width, that ready coincides with a quiet bus, and that a timeout lands in idle. Other behaviours only the bench scenarios can show. These are the order and content of the start-up bytes, the request-kind encodings, and the rule that every write follows a clean status read. They also include the exact response latency as a function of busy reads, the boundary one read short of the poll limit, and the clearing of the error flag. The bench shows them with a bus model whose busy flag stays set for a chosen number of reads.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    // request kind carried on req_kind
    typedef enum logic [1:0] {
        KIND_CMD   = 2'b00,
        KIND_CHAR  = 2'b01,
        KIND_GOTO  = 2'b10,
        KIND_GOTO2 = 2'b11
    } req_kind_e;

    // one pending bus write
    typedef struct packed {
        logic       rs;
        logic [7:0] code;
    } bus_item_t;

    typedef enum logic [2:0] {
        SQ_PWRUP,
        SQ_POLL_GO,
        SQ_POLL_WAIT,
        SQ_WR_GO,
        SQ_WR_WAIT,
        SQ_IDLE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    localparam int         START_LEN    = 4;
    localparam int         BUSY_BIT     = 7;
    localparam logic [7:0] OP_SET_ADDR  = 8'h80;
    localparam logic [7:0] OP_FUNC_8BIT = 8'h38;
    localparam logic [7:0] OP_DISP_ON   = 8'h0C;
    localparam logic [7:0] OP_CLEAR     = 8'h01;
    localparam logic [7:0] OP_ENTRY_INC = 8'h06;

    // start-up command list
    function automatic bus_item_t start_item(input logic [1:0] idx);
        bus_item_t it;
        it.rs = 1'b0;
        case (idx)
            2'd0:    it.code = OP_FUNC_8BIT;
            2'd1:    it.code = OP_DISP_ON;
            2'd2:    it.code = OP_CLEAR;
            default: it.code = OP_ENTRY_INC;
        endcase
        return it;
    endfunction

    // turn a host request into the bus write it stands for
    function automatic bus_item_t encode_req(input req_kind_e kind, input logic [7:0] data);
        bus_item_t it;
        case (kind)
            KIND_CMD:  begin it.rs = 1'b0; it.code = data; end
            KIND_CHAR: begin it.rs = 1'b1; it.code = data; end
            default:   begin it.rs = 1'b0; it.code = OP_SET_ADDR | {1'b0, data[6:0]}; end
        endcase
        return it;
    endfunction

endpackage

// File: rtl/lcd_req_encode.sv
module lcd_req_encode
    import lcd_pkg::*;
(
    input  logic [1:0] kind,
    input  logic [7:0] data,
    output bus_item_t  item
);
    always_comb begin
        item = encode_req(req_kind_e'(kind), data);
    end
endmodule

// File: rtl/lcd_bus_phy.sv
module lcd_bus_phy
    import lcd_pkg::*;
#(
    parameter int SETUP_CYCLES = 2,
    parameter int EN_CYCLES    = 12,
    parameter int HOLD_CYCLES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_read,
    input  logic       start_rs,
    input  logic [7:0] start_data,
    output logic       done,
    output logic       busy_seen,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    input  logic       flag_in
);
    localparam int MAX_A = (SETUP_CYCLES > EN_CYCLES) ? SETUP_CYCLES : EN_CYCLES;
    localparam int MAX_C = (MAX_A > HOLD_CYCLES) ? MAX_A : HOLD_CYCLES;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] SU_LAST = CW'(SETUP_CYCLES - 1);
    localparam logic [CW-1:0] EN_LAST = CW'(EN_CYCLES - 1);
    localparam logic [CW-1:0] HD_LAST = CW'(HOLD_CYCLES - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;

    assign done = (phase == PH_HOLD) && (cnt == HD_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            lcd_rs     <= 1'b0;
            lcd_rw     <= 1'b0;
            lcd_en     <= 1'b0;
            lcd_db_out <= '0;
            lcd_db_oe  <= 1'b0;
            busy_seen  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        lcd_rs     <= start_rs;
                        lcd_rw     <= start_read;
                        lcd_db_out <= start_data;
                        lcd_db_oe  <= ~start_read;
                        cnt        <= '0;
                        phase      <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == SU_LAST) begin
                        cnt    <= '0;
                        lcd_en <= 1'b1;
                        phase  <= PH_STROBE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt == EN_LAST) begin
                        cnt       <= '0;
                        lcd_en    <= 1'b0;
                        busy_seen <= flag_in;
                        phase     <= PH_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == HD_LAST) begin
                        cnt       <= '0;
                        lcd_db_oe <= 1'b0;
                        phase     <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lcd_seq.sv
module lcd_seq
    import lcd_pkg::*;
#(
    parameter int PWRUP_CYCLES = 20000,
    parameter int POLL_LIMIT   = 4096
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  bus_item_t req_item,
    output logic      req_ready,
    output logic      err_timeout,
    output logic      init_done,
    output logic      acc_start,
    output logic      acc_read,
    output bus_item_t acc_item,
    input  logic      acc_done,
    input  logic      acc_busy
);
    localparam int PW = $clog2(PWRUP_CYCLES + 1);
    localparam int LW = $clog2(POLL_LIMIT + 1);
    localparam logic [PW-1:0] PWR_LAST  = PW'(PWRUP_CYCLES - 1);
    localparam logic [LW-1:0] POLL_LAST = LW'(POLL_LIMIT - 1);
    localparam logic [1:0]    STEP_LAST = 2'(START_LEN - 1);

    seq_state_e    state;
    bus_item_t     item_q;
    logic [PW-1:0] pwr_cnt;
    logic [LW-1:0] poll_cnt;
    logic [1:0]    step;
    logic          in_start;

    assign req_ready = (state == SQ_IDLE);
    assign acc_start = (state == SQ_POLL_GO) || (state == SQ_WR_GO);
    assign acc_read  = (state == SQ_POLL_GO);

    // status reads carry rs=0 and no data
    always_comb begin
        if (state == SQ_POLL_GO) begin
            acc_item = '{rs: 1'b0, code: 8'h00};
        end else begin
            acc_item = item_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_PWRUP;
            item_q      <= '0;
            pwr_cnt     <= '0;
            poll_cnt    <= '0;
            step        <= '0;
            in_start    <= 1'b0;
            err_timeout <= 1'b0;
            init_done   <= 1'b0;
        end else begin
            case (state)
                SQ_PWRUP: begin
                    if (pwr_cnt == PWR_LAST) begin
                        item_q   <= start_item(2'd0);
                        step     <= 2'd0;
                        in_start <= 1'b1;
                        state    <= SQ_POLL_GO;
                    end else begin
                        pwr_cnt <= pwr_cnt + 1'b1;
                    end
                end
                SQ_POLL_GO: state <= SQ_POLL_WAIT;
                SQ_POLL_WAIT: begin
                    if (acc_done) begin
                        if (!acc_busy) begin
                            poll_cnt <= '0;
                            state    <= SQ_WR_GO;
                        end else if (poll_cnt == POLL_LAST) begin
                            poll_cnt    <= '0;
                            err_timeout <= 1'b1;
                            in_start    <= 1'b0;
                            state       <= SQ_IDLE;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                            state    <= SQ_POLL_GO;
                        end
                    end
                end
                SQ_WR_GO: state <= SQ_WR_WAIT;
                SQ_WR_WAIT: begin
                    if (acc_done) begin
                        if (in_start && step != STEP_LAST) begin
                            step   <= step + 1'b1;
                            item_q <= start_item(step + 1'b1);
                            state  <= SQ_POLL_GO;
                        end else begin
                            if (in_start) begin
                                init_done <= 1'b1;
                            end
                            in_start <= 1'b0;
                            state    <= SQ_IDLE;
                        end
                    end
                end
                default: begin
                    if (req_valid) begin
                        item_q      <= req_item;
                        err_timeout <= 1'b0;
                        state       <= SQ_POLL_GO;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lcd_char_ctrl.sv
module lcd_char_ctrl
    import lcd_pkg::*;
#(
    parameter int PWRUP_CYCLES = 20000,
    parameter int POLL_LIMIT   = 4096,
    parameter int SETUP_CYCLES = 2,
    parameter int EN_CYCLES    = 12,
    parameter int HOLD_CYCLES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic [7:0] req_data,
    output logic       req_ready,
    output logic       err_timeout,
    output logic       init_done,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    input  logic [7:0] lcd_db_in
);
    bus_item_t req_item;
    bus_item_t acc_item;
    logic      acc_start;
    logic      acc_read;
    logic      acc_done;
    logic      acc_busy;
    logic      unused_addr_bits;

    // only the busy bit of a status read is used
    assign unused_addr_bits = ^lcd_db_in[BUSY_BIT-1:0];

    lcd_req_encode u_enc (
        .kind (req_kind),
        .data (req_data),
        .item (req_item)
    );

    lcd_seq #(
        .PWRUP_CYCLES (PWRUP_CYCLES),
        .POLL_LIMIT   (POLL_LIMIT)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_item    (req_item),
        .req_ready   (req_ready),
        .err_timeout (err_timeout),
        .init_done   (init_done),
        .acc_start   (acc_start),
        .acc_read    (acc_read),
        .acc_item    (acc_item),
        .acc_done    (acc_done),
        .acc_busy    (acc_busy)
    );

    lcd_bus_phy #(
        .SETUP_CYCLES (SETUP_CYCLES),
        .EN_CYCLES    (EN_CYCLES),
        .HOLD_CYCLES  (HOLD_CYCLES)
    ) u_phy (
        .clk        (clk),
        .rst        (rst),
        .start      (acc_start),
        .start_read (acc_read),
        .start_rs   (acc_item.rs),
        .start_data (acc_item.code),
        .done       (acc_done),
        .busy_seen  (acc_busy),
        .lcd_rs     (lcd_rs),
        .lcd_rw     (lcd_rw),
        .lcd_en     (lcd_en),
        .lcd_db_out (lcd_db_out),
        .lcd_db_oe  (lcd_db_oe),
        .flag_in    (lcd_db_in[BUSY_BIT])
    );
endmodule

// File: rtl/lcd_char_ctrl_chk.sv
module lcd_char_ctrl_chk #(
    parameter int EN_CYCLES = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       err_timeout,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_en,
    input logic [7:0] lcd_db_out,
    input logic       lcd_db_oe
);
    int unsigned en_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_run <= 0;
        end else if (lcd_en) begin
            en_run <= en_run + 1;
        end else begin
            en_run <= 0;
        end
    end

    // R4
    oe_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_db_oe |-> !lcd_rw);

    // R5
    setup_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_en) |-> ($stable(lcd_rs) && $stable(lcd_rw)
                           && lcd_rs == $past(lcd_rs, 2) && lcd_rw == $past(lcd_rw, 2)));

    // R5
    strobe_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out)));

    // R6
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |-> (en_run == EN_CYCLES));

    // R8
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!lcd_en && !lcd_db_oe));

    // R9
    timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_timeout) |-> req_ready);
endmodule

bind lcd_char_ctrl lcd_char_ctrl_chk #(.EN_CYCLES(EN_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .err_timeout (err_timeout),
    .lcd_rs      (lcd_rs),
    .lcd_rw      (lcd_rw),
    .lcd_en      (lcd_en),
    .lcd_db_out  (lcd_db_out),
    .lcd_db_oe   (lcd_db_oe)
);

// File: tb/lcd_char_ctrl_bench.sv
module lcd_char_ctrl_bench;
    localparam int PWR = 40;
    localparam int LIM = 6;
    localparam int SU  = 2;
    localparam int EN  = 12;
    localparam int HD  = 2;
    localparam int ACC = 1 + SU + EN + HD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [7:0] req_data = 8'h00;
    logic       req_ready, err_timeout, init_done;
    logic       lcd_rs, lcd_rw, lcd_en, lcd_db_oe;
    logic [7:0] lcd_db_out, lcd_db_in;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // bus model state (owned by the monitor)
    int  busy_left = 0;
    bit  last_read_ok = 0;
    int  n_writes = 0;
    int  stab = 0, en_run = 0, hold_left = 0;
    logic prev_en = 0, prev_rs = 0, prev_rw = 0, hold_rs = 0, hold_rw = 0;
    int  kick_seen = 0;

    // stimulus-side controls
    int  busy_cfg = 2;
    int  kick_req = 0;
    int  kick_val = 0;
    logic [8:0] exp_q[$];

    always #5 clk = ~clk;

    assign lcd_db_in = (lcd_rw && !lcd_db_oe) ? {(busy_left != 0), 7'h33} : 8'h00;

    lcd_char_ctrl #(
        .PWRUP_CYCLES (PWR),
        .POLL_LIMIT   (LIM),
        .SETUP_CYCLES (SU),
        .EN_CYCLES    (EN),
        .HOLD_CYCLES  (HD)
    ) u_lcd_char_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_data(req_data), .req_ready(req_ready), .err_timeout(err_timeout),
        .init_done(init_done), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
        .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // cycle-by-cycle bus model and protocol reference
    always @(negedge clk) begin
        if (!rst) begin
            if (kick_seen != kick_req) begin
                busy_left = kick_val;
                kick_seen = kick_req;
            end
            // R4: bus driven only while writing
            chk(!(lcd_db_oe && lcd_rw), "R4", "oe during read", lcd_db_oe, 0);
            if (lcd_rs == prev_rs && lcd_rw == prev_rw) stab++;
            else stab = 0;
            if (lcd_en && !prev_en)
                chk(stab >= SU, "R5", "setup cycles", stab, SU);
            if (lcd_en) en_run++;
            if (hold_left > 0) begin
                chk(lcd_rs == hold_rs && lcd_rw == hold_rw, "R6", "hold rs/rw",
                    {lcd_rs, lcd_rw}, {hold_rs, hold_rw});
                hold_left--;
            end
            if (!lcd_en && prev_en) begin
                chk(en_run == EN, "R6", "enable width", en_run, EN);
                en_run = 0;
                hold_rs = prev_rs;
                hold_rw = prev_rw;
                chk(lcd_rs == hold_rs && lcd_rw == hold_rw, "R6", "hold rs/rw",
                    {lcd_rs, lcd_rw}, {hold_rs, hold_rw});
                hold_left = HD - 1;
                if (prev_rw) begin
                    chk(prev_rs == 1'b0, "R3", "status read rs", prev_rs, 0);
                    last_read_ok = (busy_left == 0);
                    if (busy_left > 0) busy_left--;
                end else begin
                    n_writes++;
                    chk(last_read_ok, "R3", "write without clean status read", 0, 1);
                    chk(busy_left == 0, "R3", "write while busy", busy_left, 0);
                    last_read_ok = 0;
                    if (exp_q.size() == 0) begin
                        chk(0, "R7", "unexpected write", {lcd_rs, lcd_db_out}, 0);
                    end else begin
                        logic [8:0] e;
                        e = exp_q.pop_front();
                        chk({lcd_rs, lcd_db_out} == e, "R7", "written rs/byte",
                            {lcd_rs, lcd_db_out}, e);
                    end
                    busy_left = busy_cfg;
                end
            end
            prev_en = lcd_en;
            prev_rs = lcd_rs;
            prev_rw = lcd_rw;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic send(input logic [1:0] kind, input logic [7:0] data, input bit noise,
                        output int waited, output logic err_next);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_data  = data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        err_next  = err_timeout;
        req_valid = 1'b0;
        req_kind  = ~kind;
        req_data  = ~data;
        waited = 0;
        while (!req_ready) begin
            waited++;
            if (noise) begin
                req_valid = (waited < 10);
                req_data  = 8'hAA ^ 8'(waited);
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        int w;
        int quiet_bad;
        int nw;
        logic e;
        // start-up sequence expected
        exp_q.push_back({1'b0, 8'h38});
        exp_q.push_back({1'b0, 8'h0C});
        exp_q.push_back({1'b0, 8'h01});
        exp_q.push_back({1'b0, 8'h06});

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!lcd_en && !lcd_db_oe, "R1", "bus in reset", {lcd_en, lcd_db_oe}, 0);
        chk(!req_ready && !err_timeout && !init_done, "R1", "flags in reset",
            {req_ready, err_timeout, init_done}, 0);
        rst = 1'b0;
        quiet_bad = 0;
        for (int i = 0; i < PWR; i++) begin
            @(negedge clk);
            if (lcd_en || lcd_db_oe || req_ready || init_done) quiet_bad++;
        end
        chk(quiet_bad == 0, "R1", "activity during power-up delay", quiet_bad, 0);

        // R2 start-up sequence (busy twice after each write)
        while (!req_ready) @(negedge clk);
        chk(init_done == 1'b1, "R2", "init_done", init_done, 1);
        chk(err_timeout == 1'b0, "R2", "err after start-up", err_timeout, 0);
        chk(n_writes == 4, "R2", "start-up write count", n_writes, 4);
        chk(exp_q.size() == 0, "R2", "start-up bytes pending", exp_q.size(), 0);

        // R8 latency with two busy reads left over from start-up, R7 character
        busy_cfg = 0;
        exp_q.push_back({1'b1, 8'h48});
        send(2'b01, 8'h48, 0, w, e);
        chk(w == ACC * 4, "R8", "latency, 2 busy reads", w, ACC * 4);

        // R7 command, then module busy for 3 reads
        busy_cfg = 3;
        exp_q.push_back({1'b0, 8'h01});
        send(2'b00, 8'h01, 0, w, e);
        chk(w == ACC * 2, "R8", "latency, no busy", w, ACC * 2);

        // R7 cursor address on second line, R3 three busy polls
        busy_cfg = 0;
        exp_q.push_back({1'b0, 8'hC5});
        send(2'b10, 8'h45, 0, w, e);
        chk(w == ACC * 5, "R3", "latency, 3 busy reads", w, ACC * 5);

        // R7 kind 11 also addresses, bit 7 of data dropped
        exp_q.push_back({1'b0, 8'hFF});
        send(2'b11, 8'hFF, 0, w, e);
        chk(w == ACC * 2, "R7", "latency kind 11", w, ACC * 2);

        // R8 glyph code 0 with request noise while busy
        exp_q.push_back({1'b1, 8'h00});
        send(2'b01, 8'h00, 1, w, e);
        chk(w == ACC * 2, "R8", "latency with input noise", w, ACC * 2);

        // R9 boundary: POLL_LIMIT-1 busy reads still write
        busy_cfg = LIM - 1;
        exp_q.push_back({1'b0, 8'h14});
        send(2'b00, 8'h14, 0, w, e);
        busy_cfg = 0;
        exp_q.push_back({1'b1, 8'h21});
        send(2'b01, 8'h21, 0, w, e);
        chk(w == ACC * (2 + LIM - 1), "R9", "latency at limit-1", w, ACC * (2 + LIM - 1));
        chk(err_timeout == 1'b0, "R9", "no error at limit-1", err_timeout, 0);

        // R9 timeout: busy stuck
        @(negedge clk);
        kick_val = 1000;
        kick_req++;
        @(negedge clk);
        nw = n_writes;
        send(2'b00, 8'h18, 0, w, e);
        chk(w == ACC * LIM, "R9", "cycles to timeout", w, ACC * LIM);
        chk(err_timeout == 1'b1, "R9", "err_timeout raised", err_timeout, 1);
        chk(n_writes == nw, "R9", "dropped request written", n_writes, nw);

        // R9 recovery: error clears on accept, write proceeds
        kick_val = 0;
        kick_req++;
        @(negedge clk);
        exp_q.push_back({1'b1, 8'h7E});
        send(2'b01, 8'h7E, 0, w, e);
        chk(e == 1'b0, "R9", "err cleared on accept", e, 0);
        chk(w == ACC * 2, "R8", "latency after recovery", w, ACC * 2);
        chk(exp_q.size() == 0, "R7", "expected writes left", exp_q.size(), 0);
        chk(req_ready == 1'b1, "R8", "ready in idle", req_ready, 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule